// File: doc/BRIEF.md
# EDO DRAM Controller

This controller connects a simple synchronous request port to a 4M x 16 asynchronous EDO DRAM with one multiplexed address bus. Each request carries a read/write flag, a 22-bit word address, 16 bits of write data and two byte-lane enables, and is taken with a valid/ready handshake. The controller drives the row strobe, two column strobes (one per byte lane), the write strobe, the output enable, the shared address bus and the enable of the data-bus drivers. All DRAM timing is expressed as clock-cycle counts set by parameters.

A row, once opened, stays open. Later requests to the same row run as short page cycles that only pulse the column strobes with a new column address. A request to a different row, a due refresh or a row that has been open too long closes the row with a precharge. A refresh interval timer raises a pending flag. The controller then stops taking requests, lets the current access finish, closes the page and runs a refresh cycle in which the column strobes fall before the row strobe. Read data is captured a fixed number of cycles after the column strobe falls and is returned with a one-cycle valid pulse.

The controller is one state machine with nine states. IDLE means the row strobe is high and precharge time has been met. RSU presents the row address before activation. RAH holds the row address after the row strobe falls. CSU presents the column, and sets up the write strobe and data for writes. CAS holds the column strobes low. PAGE keeps the row open with the column strobes high. PRE is precharge. REF_CAS and REF_RAS are the two phases of the refresh.

The transitions are:
- IDLE to REF_CAS when a refresh is pending.
- IDLE to RSU when a request is accepted.
- RSU to RAH, RAH to CSU, CSU to CAS, CAS to PAGE, each when its count ends.
- PAGE to PRE on a pending refresh, a row miss or an exhausted row-open budget.
- PAGE to CSU on an accepted row hit.
- PRE to IDLE.
- REF_CAS to REF_RAS.
- REF_RAS to PRE.

Top module: `edo_dram_ctrl`

## Requirements
- R1: Reset state. After reset all five strobes are high, the data drivers are off, `req_ready` is high and `rd_valid` is low.
- R2: Address split. With the default split, the row is `req_addr[21:9]` and is presented when the row strobe falls. The column is `req_addr[8:0]` and is presented when the column strobes fall. The row address is stable during the cycle before the row strobe falls.
- R3: Early write. `dram_we_n` goes low at least `T_ASC` cycles before the column strobes fall and stays low while they are low. `dq_oe` is high in those cycles. `req_be[0]` selects `dram_lcas_n` (bits 7:0) and `req_be[1]` selects `dram_ucas_n` (bits 15:8), and only the selected lanes are written.
- R4: Read. `dram_we_n` stays high and `dram_oe_n` is low while the column strobes are low, and only the lanes in `req_be` are strobed. `rd_valid` rises exactly `RD_LAT` cycles after the column strobes fall and lasts one cycle. `rd_data` lanes that were not enabled read as zero.
- R5: Page hit. A request to the open row causes no new row-strobe fall, only a column cycle with the new column address.
- R6: Row miss. A request to another row first precharges, with the row strobe high for at least `T_RP` cycles, then activates the new row.
- R7: Activation timing. The column strobes fall no earlier than `T_RAH + T_ASC` cycles after the row strobe falls.
- R8: The row strobe is never low for more than `T_RAS_MAX` consecutive cycles.
- R9: Refresh. A refresh becomes pending `REF_INT` cycles after the previous one, and stays pending until served. In the refresh cycle both column strobes are low for at least `T_CSR` cycles before the row strobe falls. During it `dram_we_n` stays high and the data drivers stay off.
- R10: The data drivers are never on while `dram_oe_n` is low, nor outside write cycles.
- R11: While a refresh is pending no request is accepted. The refresh is started once the current access and its precharge end, so refresh spacing is bounded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address (row high, column low) |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 lower, bit 1 upper |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 16 | Read data, disabled lanes zero |
| dram_ras_n | output | 1 | Row strobe |
| dram_lcas_n | output | 1 | Lower-lane column strobe |
| dram_ucas_n | output | 1 | Upper-lane column strobe |
| dram_we_n | output | 1 | Write strobe |
| dram_oe_n | output | 1 | Output enable |
| dram_addr | output | 13 | Multiplexed row/column address |
| dq_out | output | 16 | Data toward the DRAM |
| dq_oe | output | 1 | Enable of the data-bus drivers |
| dq_in | input | 16 | Data from the DRAM |

## Verification
The embedded assertions check on every cycle that the row strobe never exceeds its maximum low time, that the data drivers never fight the DRAM output enable, that the write strobe is high and the drivers are off when a refresh activates, that the row address is held across the row-strobe fall, that writes have the write strobe set up before the column strobes fall, that read valid is a single pulse, and that a pending refresh is never dropped. The scenarios exercise the remaining behaviour against a bench model of the DRAM. Data integrity over sweeps of rows, columns and byte-lane combinations, the address split, the read latency and the lane masking are only visible there. So are the absence of a second activation on a page hit, a precharge on a row miss, the measured refresh rate and refresh spacing under traffic, and the minimum activation-to-column and precharge times.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RSU,
        S_RAH,
        S_CSU,
        S_CAS,
        S_PAGE,
        S_PRE,
        S_REF_CAS,
        S_REF_RAS
    } edo_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_step_cnt.sv
module edo_step_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (clr)             cnt <= '0;
        else if (cnt != {W{1'b1}}) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
    parameter int REF_INT = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_done,
    output logic ref_pend
);
    localparam int TW = $clog2(REF_INT + 1);

    logic [TW-1:0] left;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left     <= TW'(REF_INT - 1);
            ref_pend <= 1'b0;
        end else if (ref_done) begin
            left     <= TW'(REF_INT - 1);
            ref_pend <= 1'b0;
        end else if (left == '0) begin
            ref_pend <= 1'b1;
        end else begin
            left <= left - 1'b1;
        end
    end

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pend && !ref_done) |=> ref_pend);
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9,
    parameter int T_ASR     = 1,
    parameter int T_RAH     = 1,
    parameter int T_ASC     = 1,
    parameter int T_CAS     = 2,
    parameter int RD_LAT    = 2,
    parameter int T_RP      = 3,
    parameter int T_CSR     = 1,
    parameter int T_RASR    = 4,
    parameter int T_RAS_MAX = 500,
    parameter int REF_INT   = 780
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [15:0]            req_wdata,
    input  logic [1:0]             req_be,
    output logic                   rd_valid,
    output logic [15:0]            rd_data,
    output logic                   dram_ras_n,
    output logic                   dram_lcas_n,
    output logic                   dram_ucas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [imax(ROW_W, COL_W)-1:0] dram_addr,
    output logic [15:0]            dq_out,
    output logic                   dq_oe,
    input  logic [15:0]            dq_in
);
    localparam int AW   = ROW_W + COL_W;
    localparam int DA_W = imax(ROW_W, COL_W);
    localparam int TMAX = imax(imax(imax(T_ASR, T_RAH), imax(T_ASC, T_CAS)),
                               imax(imax(T_RP, T_CSR), T_RASR));
    localparam int CW   = $clog2(TMAX + 1);
    localparam int RW   = $clog2(T_RAS_MAX + 2);

    edo_state_t state, nstate;
    logic [CW-1:0]    cnt;
    logic [RW-1:0]    ras_cnt;
    logic [ROW_W-1:0] open_row;
    logic [COL_W-1:0] cmd_col;
    logic             cmd_wr;
    logic [1:0]       cmd_be;
    logic [15:0]      cmd_wdata;
    logic             ref_pend, ref_done, step_done, hit, page_ok, accept;
    int               lim;

    edo_step_cnt #(.W(CW)) u_step (
        .clk(clk), .rst_n(rst_n), .clr(nstate != state), .cnt(cnt)
    );

    edo_refresh_timer #(.REF_INT(REF_INT)) u_ref (
        .clk(clk), .rst_n(rst_n), .ref_done(ref_done), .ref_pend(ref_pend)
    );

    always_comb begin
        unique case (state)
            S_RSU:     lim = T_ASR;
            S_RAH:     lim = T_RAH;
            S_CSU:     lim = T_ASC;
            S_CAS:     lim = T_CAS;
            S_PRE:     lim = T_RP;
            S_REF_CAS: lim = T_CSR;
            S_REF_RAS: lim = T_RASR;
            default:   lim = 1;
        endcase
    end

    assign step_done = (int'(cnt) == lim - 1);
    assign hit       = (req_addr[AW-1:COL_W] == open_row);
    assign page_ok   = (int'(ras_cnt) + T_ASC + T_CAS + 2 <= T_RAS_MAX);
    assign req_ready = !ref_pend &&
                       ((state == S_IDLE) || (state == S_PAGE && hit && page_ok));
    assign accept    = req_valid && req_ready;
    assign ref_done  = (state == S_REF_RAS) && step_done;

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:    if (ref_pend) nstate = S_REF_CAS;
                       else if (req_valid) nstate = S_RSU;
            S_RSU:     if (step_done) nstate = S_RAH;
            S_RAH:     if (step_done) nstate = S_CSU;
            S_CSU:     if (step_done) nstate = S_CAS;
            S_CAS:     if (step_done) nstate = S_PAGE;
            S_PAGE:    if (ref_pend || !page_ok || (req_valid && !hit)) nstate = S_PRE;
                       else if (req_valid) nstate = S_CSU;
            S_PRE:     if (step_done) nstate = S_IDLE;
            S_REF_CAS: if (step_done) nstate = S_REF_RAS;
            S_REF_RAS: if (step_done) nstate = S_PRE;
        endcase
    end

    // state, command and read registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            ras_cnt   <= '0;
            open_row  <= '0;
            cmd_col   <= '0;
            cmd_wr    <= 1'b0;
            cmd_be    <= 2'b00;
            cmd_wdata <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            state   <= nstate;
            ras_cnt <= dram_ras_n ? '0 : ras_cnt + 1'b1;
            if (accept) begin
                cmd_wr    <= req_write;
                cmd_col   <= req_addr[COL_W-1:0];
                cmd_be    <= req_be;
                cmd_wdata <= req_wdata;
                if (state == S_IDLE) open_row <= req_addr[AW-1:COL_W];
            end
            rd_valid <= (state == S_CAS) && !cmd_wr && (int'(cnt) == RD_LAT - 1);
            if ((state == S_CAS) && !cmd_wr && (int'(cnt) == RD_LAT - 1))
                rd_data <= dq_in & {{8{cmd_be[1]}}, {8{cmd_be[0]}}};
        end
    end

    // DRAM pin outputs
    always_comb begin
        dram_ras_n  = 1'b1;
        dram_lcas_n = 1'b1;
        dram_ucas_n = 1'b1;
        dram_we_n   = 1'b1;
        dram_oe_n   = 1'b1;
        dram_addr   = '0;
        dq_out      = cmd_wdata;
        dq_oe       = 1'b0;
        unique case (state)
            S_IDLE, S_PRE: ;
            S_RSU: dram_addr = DA_W'(open_row);
            S_RAH: begin
                dram_ras_n = 1'b0;
                dram_addr  = DA_W'(open_row);
            end
            S_CSU: begin
                dram_ras_n = 1'b0;
                dram_addr  = DA_W'(cmd_col);
                dram_we_n  = !cmd_wr;
                dq_oe      = cmd_wr;
            end
            S_CAS: begin
                dram_ras_n  = 1'b0;
                dram_addr   = DA_W'(cmd_col);
                dram_lcas_n = !cmd_be[0];
                dram_ucas_n = !cmd_be[1];
                dram_we_n   = !cmd_wr;
                dram_oe_n   = cmd_wr;
                dq_oe       = cmd_wr;
            end
            S_PAGE: begin
                dram_ras_n = 1'b0;
                dram_addr  = DA_W'(cmd_col);
            end
            S_REF_CAS: begin
                dram_lcas_n = 1'b0;
                dram_ucas_n = 1'b0;
            end
            S_REF_RAS: begin
                dram_ras_n  = 1'b0;
                dram_lcas_n = 1'b0;
                dram_ucas_n = 1'b0;
            end
        endcase
    end

    // independent run counter of the row strobe pin
    logic [RW:0] chk_ras_run;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_ras_run <= '0;
        else        chk_ras_run <= dram_ras_n ? '0 : chk_ras_run + 1'b1;
    end

    // R8
    ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (int'(chk_ras_run) < T_RAS_MAX));

    // R10
    bus_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_oe && !dram_oe_n));

    // R9
    ref_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_lcas_n && !dram_ucas_n) |-> (dram_we_n && !dq_oe));

    // R2
    row_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && dram_lcas_n && dram_ucas_n) |-> $stable(dram_addr));

    // R3
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_ras_n && !dram_we_n)
        |-> (($past(dram_we_n) == 1'b0) && dq_oe));

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: tb/edo_dram_ctrl_test.sv
`timescale 1ns/1ps
module edo_dram_ctrl_test;
    localparam int ROW_W = 13, COL_W = 9;
    localparam int T_ASR = 1, T_RAH = 1, T_ASC = 1, T_CAS = 2, RD_LAT = 2;
    localparam int T_RP = 3, T_CSR = 1, T_RASR = 4, T_RAS_MAX = 120, REF_INT = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic req_ready, rd_valid, ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe;
    logic [15:0] rd_data, dq_out, dq_model;
    logic [12:0] dram_addr;

    always #4 clk = ~clk;

    edo_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .T_ASR(T_ASR), .T_RAH(T_RAH),
        .T_ASC(T_ASC), .T_CAS(T_CAS), .RD_LAT(RD_LAT), .T_RP(T_RP), .T_CSR(T_CSR),
        .T_RASR(T_RASR), .T_RAS_MAX(T_RAS_MAX), .REF_INT(REF_INT)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_ras_n(ras_n), .dram_lcas_n(lcas_n), .dram_ucas_n(ucas_n),
        .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(dram_addr),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_model));

    int checks = 0, errors = 0;
    logic [15:0] mem [int];
    logic [15:0] shadow [int];

    // DRAM model and pin monitor, sampled at the falling clock edge
    int cyc = 0, ras_fall_cyc = 0, last_cas_cyc = 0, last_ref_cyc = 0;
    int ras_run = 0, high_run = 1000, cas_run = 0;
    int act_cnt = 0, ref_cnt = 0, ref_bad = 0, oe_bad = 0;
    int min_rcd = 1000, min_rp = 1000, max_ras = 0, max_ref_gap = 0;
    int cur_row = 0, last_wr = -1, last_rd = -1;
    logic [1:0] lanes = 2'b00;
    logic p_ras = 1'b1, p_l = 1'b1, p_u = 1'b1;

    initial dq_model = 16'h0000;

    always @(negedge clk) begin
        if (rst_n) begin
            int key;
            cyc++;
            if (p_ras && !ras_n) begin
                if (!lcas_n && !ucas_n) begin
                    ref_cnt++;
                    if (!we_n || dq_oe || cas_run < T_CSR) ref_bad++;
                    if (last_ref_cyc != 0 && cyc - last_ref_cyc > max_ref_gap)
                        max_ref_gap = cyc - last_ref_cyc;
                    last_ref_cyc = cyc;
                end else begin
                    act_cnt++;
                    cur_row = int'(dram_addr);
                    ras_fall_cyc = cyc;
                    if (high_run < min_rp) min_rp = high_run;
                end
            end
            if (!ras_n && p_l && p_u && (!lcas_n || !ucas_n)) begin
                key = cur_row * (1 << COL_W) + int'(dram_addr[COL_W-1:0]);
                lanes = {~ucas_n, ~lcas_n};
                last_cas_cyc = cyc;
                if (cyc - ras_fall_cyc < min_rcd) min_rcd = cyc - ras_fall_cyc;
                if (!we_n) begin
                    logic [15:0] w;
                    if (!dq_oe) oe_bad++;
                    w = mem.exists(key) ? mem[key] : 16'h0000;
                    if (!lcas_n) w[7:0]  = dq_out[7:0];
                    if (!ucas_n) w[15:8] = dq_out[15:8];
                    mem[key] = w;
                    last_wr = key;
                end else begin
                    dq_model = mem.exists(key) ? mem[key] : 16'h0000;
                    last_rd = key;
                end
            end
            if (!oe_n && dq_oe) oe_bad++;
            if (dq_oe && we_n) oe_bad++;
            ras_run  = ras_n ? 0 : ras_run + 1;
            high_run = ras_n ? high_run + 1 : 0;
            cas_run  = (!lcas_n && !ucas_n) ? cas_run + 1 : 0;
            if (ras_run > max_ras) max_ras = ras_run;
            p_ras = ras_n; p_l = lcas_n; p_u = ucas_n;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic issue(input bit wr, input int addr, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = 22'(addr); req_wdata = d; req_be = be;
        #1;
        while (!req_ready) begin @(negedge clk); #2; end
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic do_write(input int addr, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] e;
        issue(1'b1, addr, d, be);
        repeat (T_ASC + T_CAS + 3) @(negedge clk);
        #1;
        e = shadow.exists(addr) ? shadow[addr] : 16'h0000;
        if (be[0]) e[7:0]  = d[7:0];
        if (be[1]) e[15:8] = d[15:8];
        shadow[addr] = e;
        chk(last_wr == addr, "R2", "write address split", last_wr, addr);
        chk(lanes == be, "R3", "write lane strobes", lanes, be);
        chk(mem.exists(addr) && mem[addr] == e, "R3", "stored word",
            mem.exists(addr) ? mem[addr] : 16'hxxxx, e);
    endtask

    task automatic do_read(input int addr, input logic [1:0] be);
        logic [15:0] e;
        int n = 0;
        issue(1'b0, addr, 16'h0000, be);
        #1;
        while (!rd_valid && n < 60) begin @(negedge clk); #2; n++; end
        e = shadow.exists(addr) ? shadow[addr] : 16'h0000;
        e = e & {{8{be[1]}}, {8{be[0]}}};
        chk(rd_valid, "R4", "read valid seen", rd_valid, 1);
        chk(rd_data == e, "R4", "read data", rd_data, e);
        chk(cyc - last_cas_cyc == RD_LAT, "R4", "read latency", cyc - last_cas_cyc, RD_LAT);
        chk(last_rd == addr && lanes == be, "R2", "read address and lanes", last_rd, addr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int rows[4] = '{0, 1, 4100, 8191};
        int cols[4] = '{0, 1, 256, 511};
        int a0, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk({ras_n, lcas_n, ucas_n, we_n, oe_n} == 5'b11111, "R1", "strobes idle",
            {ras_n, lcas_n, ucas_n, we_n, oe_n}, 5'b11111);
        chk(!dq_oe && req_ready && !rd_valid, "R1", "bus off, ready, no valid",
            {dq_oe, req_ready, rd_valid}, 3'b010);

        // sweep over rows, columns and lane combinations (R2, R3, R4)
        foreach (rows[i]) foreach (cols[j]) begin
            int a = rows[i] * (1 << COL_W) + cols[j];
            for (int k = 1; k <= 3; k++)
                do_write(a, 16'((a * 37 + k * 4099) & 16'hffff), 2'(k));
            for (int k = 3; k >= 1; k--)
                do_read(a, 2'(k));
        end

        // page hits, then row miss (R5, R6): start just after a refresh
        a0 = ref_cnt;
        while (ref_cnt == a0) @(negedge clk);
        repeat (T_RP + 2) @(negedge clk);
        r0 = act_cnt;
        for (int c = 10; c < 14; c++) do_write(77 * (1 << COL_W) + c, 16'(c * 3 + 1), 2'b11);
        chk(act_cnt - r0 == 1, "R5", "activations for four same-row writes", act_cnt - r0, 1);
        do_read(77 * (1 << COL_W) + 12, 2'b11);
        chk(act_cnt - r0 == 1, "R5", "activations after same-row read", act_cnt - r0, 1);
        do_write(78 * (1 << COL_W) + 3, 16'h5a5a, 2'b11);
        chk(act_cnt - r0 == 2, "R6", "activation on row miss", act_cnt - r0, 2);
        chk(min_rp >= T_RP, "R6", "minimum precharge", min_rp, T_RP);
        chk(min_rcd >= T_RAH + T_ASC, "R7", "row to column delay", min_rcd, T_RAH + T_ASC);

        // open page left idle must close in time (R8) and refresh rate (R9)
        a0 = ref_cnt;
        repeat (2000) @(negedge clk);
        #1;
        chk(max_ras <= T_RAS_MAX, "R8", "longest row strobe low", max_ras, T_RAS_MAX);
        chk(ras_n, "R8", "page closed after idle", ras_n, 1);
        chk(ref_cnt - a0 >= 2000 / (REF_INT + 20) && ref_cnt - a0 <= 2000 / REF_INT + 1,
            "R9", "refresh count in 2000 cycles", ref_cnt - a0, 2000 / REF_INT);
        chk(ref_bad == 0, "R9", "refresh strobe order and write high", ref_bad, 0);
        chk(oe_bad == 0, "R10", "data driver misuse", oe_bad, 0);
        chk(max_ref_gap <= REF_INT + T_ASR + T_RAH + T_ASC + T_CAS + T_RP + T_CSR + T_RASR + 6,
            "R11", "refresh spacing under traffic", max_ref_gap, REF_INT);
        finish_run();
    end
endmodule